// File: doc/BRIEF.md
# Byte-Parallel Header CRC-8 Generator

This block computes an 8-bit header check value over a stream of bytes. The generator polynomial is x^8 + x^2 + x + 1 and the seed is zero. In byte mode it absorbs one whole byte per handshake through a fixed XOR network. The result is identical to pushing that byte, most significant bit first, through a serial LFSR. The CRC register is available on `crc_o` at all times and can be read after any byte.

A bit-serial mode processes each accepted byte over eight cycles, one bit per cycle. It exists to cross-check the byte network. The data input is a valid/ready stream. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. It stays high in byte mode. After a serial-mode byte is accepted it drops for the seven cycles that finish that byte, so the source must hold off until it rises again. `start_i` and `serial_i` are plain control pins that are sampled only while `in_ready` is high.

Top module: `crc8_hec_gen`

## Requirements
- R1: In byte mode (`serial_i`=0), an accepted byte D updates the register C in the next cycle to the value obtained by shifting D MSB first (D[7] first) through an LFSR. For each bit, feedback = bit XOR C[7], the register shifts left by one, and the feedback is XORed into bits 0, 1 and 2 (polynomial 0x07).
- R2: `start_i` high on an accepting cycle makes the byte absorb from a seed of 0x00 instead of the current register.
- R3: `start_i` high while `in_ready`=1 and `in_valid`=0 sets `crc_o` to 0x00 in the next cycle.
- R4: With `in_ready`=1, `in_valid`=0 and `start_i`=0, `crc_o` keeps its value.
- R5: A byte accepted with `serial_i`=1 is processed one bit per cycle: one bit in the acceptance cycle and seven in the cycles after it. `in_ready` is low for exactly 7 cycles after acceptance. The final register equals the R1 result for the same seed and byte.
- R6: While `in_ready` is low, `in_valid`, `in_data`, `start_i` and `serial_i` have no effect. In byte mode `in_ready` is high on every cycle.
- R7: Synchronous `rst` forces `crc_o` to 0x00 and `in_ready` to 1 in the next cycle. It overrides every other input, including a serial byte in progress.
- R8: `crc_o[0]` is register bit C0 and `crc_o[7]` is C7. From a cleared register, byte 0x00 gives 0x00, byte 0x01 gives 0x07, and the ASCII string "123456789" gives 0xF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start of a new check: clears the register or zero-seeds the accepted byte |
| serial_i | input | 1 | 1 = bit-serial processing, 0 = byte-parallel |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Data byte, bit 7 processed first |
| crc_o | output | 8 | Current CRC register, C7 in bit 7 |

## Verification
Several properties are checked on every clock cycle:
- the register holds while idle;
- an idle start strobe clears it;
- the handshake drops for a serial byte and stays up in byte mode;
- a zero byte from a zero seed gives zero;
- reset leaves a cleared, ready block.

The arithmetic itself can only be shown by the bench scenarios. These compare every byte value, chained byte pairs and a known string against a bitwise model. They also show that the serial path matches the byte path, that inputs are ignored during back-pressure, and that a reset aborts a serial byte.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W  = 8;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CRC_W-1:0] GEN_POLY = 8'h07;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Per output bit: which of the combined terms (reg bit XOR data bit) feed it.
  localparam logic [BYTE_W-1:0] BYTE_TAPS [CRC_W] = '{
    8'hC1, 8'h43, 8'h47, 8'h8E, 8'h1C, 8'h38, 8'h70, 8'hE0
  };
endpackage

// File: rtl/crc8_byte_net.sv
module crc8_byte_net
  import crc8_pkg::*;
(
  input  crc_t  cur_i,
  input  byte_t dat_i,
  output crc_t  nxt_o
);
  byte_t mix;
  assign mix = cur_i ^ dat_i;

  for (genvar n = 0; n < CRC_W; n++) begin : g_bit
    assign nxt_o[n] = ^(mix & BYTE_TAPS[n]);
  end
endmodule

// File: rtl/crc8_bit_net.sv
module crc8_bit_net
  import crc8_pkg::*;
#(
  parameter crc_t POLY = GEN_POLY
) (
  input  crc_t cur_i,
  input  logic bit_i,
  output crc_t nxt_o
);
  logic fb;
  assign fb    = cur_i[CRC_W-1] ^ bit_i;
  assign nxt_o = {cur_i[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/crc8_serial_seq.sv
module crc8_serial_seq
  import crc8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  byte_t      dat_i,
  output logic       busy_o,
  output logic       bit_o
);
  logic [CNT_W-1:0] left_q;
  byte_t            sh_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
      sh_q   <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      left_q <= CNT_W'(BYTE_W - 1);
      sh_q   <= {dat_i[BYTE_W-2:0], 1'b0};
    end else if (busy_q) begin
      left_q <= left_q - 1'b1;
      sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
      if (left_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign bit_o  = sh_q[BYTE_W-1];

  p_load_idle_r6: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_q) else $error("serial load while busy");
  p_busy_count_r5: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> left_q != '0) else $error("busy with no bits left");
endmodule

// File: rtl/crc8_hec_gen.sv
module crc8_hec_gen
  import crc8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       serial_i,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic [7:0] crc_o
);
  crc_t crc_q, crc_d, seed, byte_nxt, bit_nxt, bit_cur;
  logic accept, ser_load, busy, ser_bit, bit_in, rst_d1;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign ser_load = accept && serial_i;
  assign seed     = (start_i && in_ready) ? '0 : crc_q;
  assign bit_cur  = busy ? crc_q : seed;
  assign bit_in   = busy ? ser_bit : in_data[BYTE_W-1];

  crc8_serial_seq u_seq (
    .clk(clk), .rst(rst), .load_i(ser_load), .dat_i(in_data),
    .busy_o(busy), .bit_o(ser_bit)
  );

  crc8_byte_net u_byte (.cur_i(seed), .dat_i(in_data), .nxt_o(byte_nxt));

  crc8_bit_net #(.POLY(GEN_POLY)) u_bit (
    .cur_i(bit_cur), .bit_i(bit_in), .nxt_o(bit_nxt)
  );

  always_comb begin
    if (accept && !serial_i)      crc_d = byte_nxt;
    else if (ser_load || busy)    crc_d = bit_nxt;
    else if (start_i && in_ready) crc_d = '0;
    else                          crc_d = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else     crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  always_ff @(posedge clk) begin
    rst_d1 <= rst;
    if (rst_d1) begin
      p_reset_clears_r7: assert (crc_q == '0 && in_ready)
        else $error("reset did not clear");
    end
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid && !start_i) |=> $stable(crc_o))
    else $error("idle register changed");
  p_idle_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && start_i && !in_valid) |=> crc_o == '0)
    else $error("idle start did not clear");
  p_zero_seed_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && start_i && !serial_i && in_data == '0) |=> crc_o == '0)
    else $error("zero byte from zero seed not zero");
  p_serial_stall_r5: assert property (@(posedge clk) disable iff (rst)
    ser_load |=> !in_ready) else $error("ready after serial accept");
  p_byte_ready_r6: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !(in_valid && serial_i)) |=> in_ready)
    else $error("ready dropped in byte mode");
endmodule

// File: tb/test_crc8_hec_gen.sv
module test_crc8_hec_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, serial_i = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic [7:0] crc_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc8_hec_gen i_crc8_hec_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .serial_i(serial_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .crc_o(crc_o)
  );

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic st, input logic ser);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = b; start_i = st; serial_i = ser;
    @(negedge clk);
    in_valid = 1'b0; start_i = 1'b0; serial_i = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] exp, seed;
    repeat (3) @(negedge clk);
    check("R7 reset crc", crc_o, 8'h00);
    check("R7 reset ready", {7'b0, in_ready}, 8'h01);
    rst = 1'b0;

    // R8 known vectors
    send(8'h00, 1, 0); check("R8 zero byte", crc_o, 8'h00);
    send(8'h01, 1, 0); check("R8 byte 01", crc_o, 8'h07);
    send(8'h31, 1, 0);
    for (int k = 2; k <= 9; k++) send(8'h30 + 8'(k), 0, 0);
    check("R8 string 123456789", crc_o, 8'hF4);

    // R1/R2: every byte from zero seed, then chained second byte
    for (int b = 0; b < 256; b++) begin
      send(8'(b), 1, 0);
      exp = ref_step(8'h00, 8'(b));
      check("R2 zero-seeded byte", crc_o, exp);
      send(8'((b * 37 + 11) & 255), 0, 0);
      exp = ref_step(exp, 8'((b * 37 + 11) & 255));
      check("R1 chained byte", crc_o, exp);
    end

    // R5: serial equivalence over every byte, chained
    seed = 8'h00;
    send(8'h00, 1, 0);
    for (int b = 0; b < 256; b++) begin
      send(8'(b ^ 8'h5A), 0, 1);
      seed = ref_step(seed, 8'(b ^ 8'h5A));
      check("R5 serial equals byte result", crc_o, seed);
    end

    // R5: ready low for exactly 7 cycles
    begin
      int lo = 0;
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h3C; start_i = 1'b1; serial_i = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; start_i = 1'b0; serial_i = 1'b0;
      while (!in_ready && lo < 20) begin lo++; @(negedge clk); end
      check("R5 stall length", 8'(lo), 8'd7);
      check("R5 serial start byte", crc_o, ref_step(8'h00, 8'h3C));
    end

    // R6: inputs ignored during back-pressure
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hA5; start_i = 1'b1; serial_i = 1'b1;
    @(negedge clk);
    in_data = 8'hFF; serial_i = 1'b0;
    repeat (7) begin
      check("R6 ready low while busy", {7'b0, in_ready}, 8'h00);
      @(negedge clk);
    end
    in_valid = 1'b0; start_i = 1'b0;
    check("R6 busy inputs ignored", crc_o, ref_step(8'h00, 8'hA5));

    // R6: byte mode ready every cycle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(k); start_i = 1'b0;
      check("R6 byte mode ready", {7'b0, in_ready}, 8'h01);
    end
    @(negedge clk); in_valid = 1'b0;
    exp = ref_step(ref_step(ref_step(ref_step(ref_step(8'h00, 8'hA5), 0), 1), 2), 3);
    check("R1 back-to-back bytes", crc_o, exp);

    // R4 hold
    repeat (5) @(negedge clk);
    check("R4 idle hold", crc_o, exp);

    // R3 idle clear
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    check("R3 idle clear", crc_o, 8'h00);

    // R7 reset aborts serial work
    send(8'h77, 0, 0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hC3; serial_i = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; serial_i = 1'b0;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; start_i = 1'b1; in_data = 8'hFF;
    @(negedge clk);
    check("R7 reset aborts crc", crc_o, 8'h00);
    check("R7 reset aborts ready", {7'b0, in_ready}, 8'h01);
    @(negedge clk);
    check("R7 reset overrides valid", crc_o, 8'h00);
    rst = 1'b0; in_valid = 1'b0; start_i = 1'b0;
    send(8'h01, 0, 0);
    check("R7 clean after reset", crc_o, 8'h07);

    done = 1'b1;
    finish_run();
  end
endmodule